// File: doc/BRIEF.md
# Register Rename Map and Free List

This block is the renaming stage of an out-of-order core whose integer and floating-point values share one physical register file of 16 entries, tagged 1 to 16. It holds the current physical tag and a ready flag for each of eight architectural registers. It also keeps a queue of tags that no register currently holds. Each cycle at most one instruction is presented. The block reports the physical tags and ready flags of its two sources. If the instruction writes a register, the block takes a fresh tag from the queue, installs it as the new mapping and hands back the tag it displaced. The retire stage frees that displaced tag later.

Two other inputs update the state. A completion broadcast marks ready every mapping whose current tag matches the broadcast tag. A release port puts retired tags back at the tail of the queue. If an instruction needs a tag and the queue is empty, it is held back and no rename state changes.

Top module: `rename_unit`

## Requirements
- R1: The architectural index encoding is 0..3 for f0..f3 and 4..7 for r1..r4. After reset, index i maps to physical tag i+1 (f0→1, f1→2, f2→3, f3→4, r1→5 … r4→8), and every mapping is ready.
- R2: After reset the free queue holds tags 9 to 16. Allocation hands out tags in queue order, oldest first, so the first tags allocated after reset are 9, 10, 11 and so on. `new_tag` shows the tag the next allocation will take.
- R3: A rename with a destination writes the allocated tag into that register's entry and clears its ready flag. Both changes are visible on a source lookup from the next cycle.
- R4: In the cycle of a rename, `old_tag` equals the mapping that the destination register held before the rename.
- R5: Source lookups reflect the registered state before that cycle's updates. A register that is both source and destination reports its old tag. A broadcast becomes visible from the next cycle.
- R6: A broadcast sets the ready flag of every entry whose current tag equals `cdb_tag`. If the same entry is renamed in that cycle, the entry ends with the new tag and not ready.
- R7: A broadcast tag that matches no current mapping leaves every ready flag unchanged.
- R8: A released tag is appended at the tail of the free queue. A release and an allocation in the same cycle both take effect.
- R9: When the queue is empty and a valid instruction has a destination, `ren_stall` is 1, `ren_fire` is 0, and the map and queue head are unchanged. A valid instruction without a destination still fires while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| src_a_idx | input | 3 | Architectural index of source A |
| src_b_idx | input | 3 | Architectural index of source B |
| dst_valid | input | 1 | The instruction writes a destination |
| dst_idx | input | 3 | Architectural index of the destination |
| src_a_tag | output | 5 | Physical tag of source A |
| src_a_rdy | output | 1 | Source A value is available |
| src_b_tag | output | 5 | Physical tag of source B |
| src_b_rdy | output | 1 | Source B value is available |
| new_tag | output | 5 | Tag at the head of the free queue (allocated on a firing rename) |
| old_tag | output | 5 | Previous mapping of the destination |
| ren_fire | output | 1 | The presented instruction is renamed this cycle |
| ren_stall | output | 1 | The presented instruction is held for lack of a free tag |
| cdb_valid | input | 1 | Completion broadcast present |
| cdb_tag | input | 5 | Broadcast physical tag |
| rel_valid | input | 1 | A retired tag is being freed |
| rel_tag | input | 5 | Tag being freed |

## Verification
The hardest states to reach are those where the free queue is empty or holds a single tag. They are reached by renaming repeatedly without releasing anything until the queue runs dry. While the queue is empty the bench presents an instruction with a destination and one without. It then makes a release coincide with a held instruction, and after that makes a release and an allocation coincide with one tag left. A broadcast of a displaced tag that is still waiting for retirement is the stale-tag case. A broadcast that coincides with a rename of the matching register covers the remaining ordering case.

// File: rtl/rename_pkg.sv
package rename_pkg;
    parameter int DEF_ARCH_N = 8;
    parameter int DEF_PHYS_N = 16;

    // first tag left unmapped after reset
    function automatic int first_spare_tag(input int arch_n);
        return arch_n + 1;
    endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int ARCH_N = 8,
    parameter int TAG_W  = 5,
    localparam int IDX_W = $clog2(ARCH_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [TAG_W-1:0] rd_a_tag,
    output logic             rd_a_rdy,
    output logic [TAG_W-1:0] rd_b_tag,
    output logic             rd_b_rdy,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [TAG_W-1:0] wr_old_tag,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag
);
    typedef struct packed {
        logic [ARCH_N-1:0][TAG_W-1:0] tag;
        logic [ARCH_N-1:0]            rdy;
    } map_st_t;

    map_st_t           st_d, st_q;
    logic [ARCH_N-1:0] cdb_match;

    function automatic map_st_t reset_state();
        map_st_t s;
        for (int i = 0; i < ARCH_N; i++) begin
            s.tag[i] = TAG_W'(i + 1);
            s.rdy[i] = 1'b1;
        end
        return s;
    endfunction

    // lookups use registered state only
    assign rd_a_tag   = st_q.tag[rd_a_idx];
    assign rd_a_rdy   = st_q.rdy[rd_a_idx];
    assign rd_b_tag   = st_q.tag[rd_b_idx];
    assign rd_b_rdy   = st_q.rdy[rd_b_idx];
    assign wr_old_tag = st_q.tag[wr_idx];

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ARCH_N; i++) begin
            cdb_match[i] = cdb_valid && (st_q.tag[i] == cdb_tag);
            if (cdb_match[i]) begin
                st_d.rdy[i] = 1'b1;
            end
        end
        // rename overrides a broadcast on the same entry
        if (wr_en) begin
            st_d.tag[wr_idx] = wr_tag;
            st_d.rdy[wr_idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    rename_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.tag[$past(wr_idx)] == $past(wr_tag)) && !st_q.rdy[$past(wr_idx)]);

    // R7
    stale_cdb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cdb_valid && (cdb_match == '0) && !wr_en) |=> $stable(st_q.rdy));

    for (genvar g = 0; g < ARCH_N; g++) begin : g_rdy_chk
        // R6
        cdb_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cdb_match[g] && !(wr_en && (wr_idx == IDX_W'(g)))) |=> st_q.rdy[g]);
    end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int DEPTH     = 8,
    parameter int TAG_W     = 5,
    parameter int FIRST_TAG = 9,
    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic [TAG_W-1:0] head_tag,
    output logic             empty
);
    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0] slot;
        logic [PTR_W-1:0]            rd_ptr;
        logic [PTR_W-1:0]            wr_ptr;
        logic [CNT_W-1:0]            cnt;
    } fl_st_t;

    fl_st_t st_d, st_q;
    logic   full;

    function automatic fl_st_t reset_state();
        fl_st_t s;
        for (int j = 0; j < DEPTH; j++) begin
            s.slot[j] = TAG_W'(FIRST_TAG + j);
        end
        s.rd_ptr = '0;
        s.wr_ptr = '0;
        s.cnt    = CNT_W'(DEPTH);
        return s;
    endfunction

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head_tag = st_q.slot[st_q.rd_ptr];
    assign empty    = (st_q.cnt == '0);
    assign full     = (st_q.cnt == CNT_W'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (pop) begin
            st_d.rd_ptr = bump(st_q.rd_ptr);
        end
        if (push) begin
            st_d.slot[st_q.wr_ptr] = push_tag;
            st_d.wr_ptr            = bump(st_q.wr_ptr);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R8
    push_pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(st_q.cnt));

    // R2
    pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int ARCH_N  = rename_pkg::DEF_ARCH_N,
    parameter int PHYS_N  = rename_pkg::DEF_PHYS_N,
    localparam int TAG_W  = $clog2(PHYS_N + 1),
    localparam int IDX_W  = $clog2(ARCH_N),
    localparam int FL_DEP = PHYS_N - ARCH_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_valid,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic             dst_valid,
    input  logic [IDX_W-1:0] dst_idx,
    output logic [TAG_W-1:0] src_a_tag,
    output logic             src_a_rdy,
    output logic [TAG_W-1:0] src_b_tag,
    output logic             src_b_rdy,
    output logic [TAG_W-1:0] new_tag,
    output logic [TAG_W-1:0] old_tag,
    output logic             ren_fire,
    output logic             ren_stall,
    input  logic             cdb_valid,
    input  logic [TAG_W-1:0] cdb_tag,
    input  logic             rel_valid,
    input  logic [TAG_W-1:0] rel_tag
);
    logic fl_empty;
    logic alloc;

    assign ren_stall = ren_valid && dst_valid && fl_empty;
    assign ren_fire  = ren_valid && !ren_stall;
    assign alloc     = ren_fire && dst_valid;

    rn_map_table #(
        .ARCH_N (ARCH_N),
        .TAG_W  (TAG_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (src_a_idx),
        .rd_b_idx   (src_b_idx),
        .rd_a_tag   (src_a_tag),
        .rd_a_rdy   (src_a_rdy),
        .rd_b_tag   (src_b_tag),
        .rd_b_rdy   (src_b_rdy),
        .wr_en      (alloc),
        .wr_idx     (dst_idx),
        .wr_tag     (new_tag),
        .wr_old_tag (old_tag),
        .cdb_valid  (cdb_valid),
        .cdb_tag    (cdb_tag)
    );

    rn_free_list #(
        .DEPTH     (FL_DEP),
        .TAG_W     (TAG_W),
        .FIRST_TAG (rename_pkg::first_spare_tag(ARCH_N))
    ) u_fl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (rel_valid),
        .push_tag (rel_tag),
        .head_tag (new_tag),
        .empty    (fl_empty)
    );

    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_stall && !rel_valid) |=> $stable(new_tag) && $stable(fl_empty));

    // R2
    tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (new_tag != '0) && (new_tag <= TAG_W'(PHYS_N)));
endmodule

// File: tb/sim_rename_unit.sv
module sim_rename_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0;
    logic [2:0] src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
    logic       dst_valid = 1'b0;
    logic [4:0] src_a_tag, src_b_tag, new_tag, old_tag;
    logic       src_a_rdy, src_b_rdy, ren_fire, ren_stall;
    logic       cdb_valid = 1'b0, rel_valid = 1'b0;
    logic [4:0] cdb_tag = '0, rel_tag = '0;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    int emap[8];
    bit erdy[8];
    int fl[$];
    int pend[$];

    always #10 clk = ~clk;

    rename_unit u0 (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .dst_valid(dst_valid), .dst_idx(dst_idx),
        .src_a_tag(src_a_tag), .src_a_rdy(src_a_rdy),
        .src_b_tag(src_b_tag), .src_b_rdy(src_b_rdy),
        .new_tag(new_tag), .old_tag(old_tag),
        .ren_fire(ren_fire), .ren_stall(ren_stall),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .rel_valid(rel_valid), .rel_tag(rel_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check before posedge, update model after
    task automatic cyc(input bit v, input int s1, input int s2, input bit hd, input int d,
                       input bit cv, input int ct, input bit rv, input int rt, input string lbl);
        bit xs;
        ren_valid = v; src_a_idx = 3'(s1); src_b_idx = 3'(s2);
        dst_valid = hd; dst_idx = 3'(d);
        cdb_valid = cv; cdb_tag = 5'(ct); rel_valid = rv; rel_tag = 5'(rt);
        #2;
        chk(src_a_tag == 5'(emap[s1]), lbl, src_a_tag, emap[s1]);
        chk(src_a_rdy == erdy[s1], lbl, src_a_rdy, erdy[s1]);
        chk(src_b_tag == 5'(emap[s2]), lbl, src_b_tag, emap[s2]);
        chk(src_b_rdy == erdy[s2], lbl, src_b_rdy, erdy[s2]);
        xs = v && hd && (fl.size() == 0);
        chk(ren_stall == xs, "R9 stall", ren_stall, xs);
        chk(ren_fire == (v && !xs), "R9 fire", ren_fire, v && !xs);
        if (v && hd && !xs) begin
            chk(new_tag == 5'(fl[0]), "R2 new_tag", new_tag, fl[0]);
            chk(old_tag == 5'(emap[d]), "R4 old_tag", old_tag, emap[d]);
        end
        @(posedge clk);
        if (cv) for (int i = 0; i < 8; i++) if (emap[i] == ct) erdy[i] = 1'b1;
        if (v && hd && !xs) begin
            pend.push_back(emap[d]);
            emap[d] = fl.pop_front();
            erdy[d] = 1'b0;
        end
        if (rv) fl.push_back(rt);
        @(negedge clk);
        ren_valid = 1'b0; cdb_valid = 1'b0; rel_valid = 1'b0;
    endtask

    task automatic look_all(input string lbl);
        for (int i = 0; i < 8; i++) cyc(0, i, 7 - i, 0, 0, 0, 0, 0, 0, lbl);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int rt;
        for (int i = 0; i < 8; i++) begin emap[i] = i + 1; erdy[i] = 1'b1; end
        for (int t = 9; t <= 16; t++) fl.push_back(t);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset mapping and readiness
        look_all("R1 reset map");

        // R2 R3 R4: load into f1 reading r1, then multiply f1*f3 into f0
        cyc(1, 4, 4, 1, 1, 0, 0, 0, 0, "R5 src");
        chk(emap[1] == 9 && pend[$] == 2, "R2 first alloc", emap[1], 9);
        cyc(1, 1, 3, 1, 0, 0, 0, 0, 0, "R3 src after rename");
        chk(emap[0] == 10 && pend[$] == 1, "R4 second alloc", emap[0], 10);

        // R5 same register as source and destination
        cyc(1, 4, 5, 1, 4, 0, 0, 0, 0, "R5 same reg");
        cyc(0, 4, 1, 0, 0, 0, 0, 0, 0, "R3 r1 renamed");

        // R6 wake f1, and broadcast f0's tag while f0 is renamed
        cyc(0, 1, 0, 0, 0, 1, 9, 0, 0, "R5 pre-wake");
        cyc(1, 1, 0, 1, 0, 1, 10, 0, 0, "R6 wake visible");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, "R6 renamed stays busy");

        // R7 stale broadcast of a displaced tag
        cyc(0, 0, 0, 0, 0, 1, pend[0], 0, 0, "R7 stale");
        look_all("R7 after stale");

        // R8 sweep: one rename and one release per cycle
        for (int k = 0; k < 64; k++) begin
            bit rv = pend.size() > 0;
            rt = rv ? pend.pop_front() : 0;
            cyc(1, k % 8, (k * 3) % 8, (k % 5) != 4, k % 8,
                (k % 3) == 0, ((k * 5) % 16) + 1, rv, rt, "R8 sweep src");
        end
        look_all("R3 sweep end");

        // R9 drain the queue, then stall
        while (fl.size() > 0) cyc(1, 2, 6, 1, (fl.size() + 3) % 8, 0, 0, 0, 0, "R2 drain");
        cyc(1, 5, 6, 1, 5, 0, 0, 0, 0, "R9 stall src");
        look_all("R9 map unchanged");
        cyc(1, 3, 7, 0, 0, 0, 0, 0, 0, "R9 no-dst fires");
        // stall with a release in the same cycle: release is kept
        rt = pend.pop_front();
        cyc(1, 0, 1, 1, 2, 0, 0, 1, rt, "R9 stall with release");
        // one tag left: allocate and release together
        rt = pend.pop_front();
        cyc(1, 2, 2, 1, 2, 0, 0, 1, rt, "R8 push+pop");
        cyc(1, 3, 2, 1, 3, 0, 0, 0, 0, "R8 popped released tag");
        cyc(1, 3, 3, 1, 3, 0, 0, 0, 0, "R9 empty again");

        // R2 R8 return all displaced tags, then reallocate in FIFO order
        while (pend.size() > 0) begin
            rt = pend.pop_front();
            cyc(0, 0, 0, 0, 0, 0, 0, 1, rt, "R8 release");
        end
        for (int k = 0; k < 8; k++) cyc(1, k, 7 - k, 1, k, 1, emap[(k + 3) % 8], 0, 0, "R2 fifo order");
        look_all("R6 final");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule